// File: doc/BRIEF.md
# Shared-Pin Bit-Clock Mode and De-Emphasis Decoder

This block watches one input pin that a board may wire either to an external serial bit clock or to a static control level that requests de-emphasis. It tells the two uses apart by counting rising edges on the pin within each phase of the frame (left/right) clock. A burst of rising edges within one phase selects external bit-clock mode. Frames with no edges at all return it to internal bit-clock mode. In internal mode the pin is a level. That level is sampled at each falling edge of the frame clock and debounced over a run of identical samples, which yields a de-emphasis enable.

The block runs entirely on the master clock. The pin and the frame clock pass through a two-flop synchroniser and an edge detector. Two small state machines form the core. The mode machine has two states: `MODE_INT` (internal bit clock) and `MODE_EXT` (external bit clock). Its transitions are *burst detected* (`MODE_INT` to `MODE_EXT`) and *quiet timeout* (`MODE_EXT` to `MODE_INT`). The de-emphasis machine has two states: `DE_OFF` and `DE_ON`. Its transitions are *low run complete* (`DE_OFF` to `DE_ON`), *high run complete* (`DE_ON` to `DE_OFF`) and *external override* (`DE_ON` to `DE_OFF` whenever the mode is external). The de-emphasis enable reaches the output only while the single-speed input is high.

Top module: `shared_pin_decoder`

## Requirements
- R1: `ext_mode_o` goes high once 16 rising edges of `pin_i` arrive within one phase of `frame_i`. The phase may be high or low.
- R2: The rising-edge count restarts at every transition of `frame_i`. Edges that are split across two phases, 10 in one and 10 in the next, leave `ext_mode_o` low.
- R3: A frame is the interval that ends at a falling edge of `frame_i`. In external mode, `ext_mode_o` returns low at the falling edge that completes the second consecutive frame with no rising edge on `pin_i`. Any frame that contains a rising edge restarts that count.
- R4: In internal mode the de-emphasis state turns on when `pin_i` is low (0) at 5 consecutive falling edges of `frame_i`. It turns off when `pin_i` is high (1) at 5 consecutive falling edges.
- R5: When a sampled level differs from the previous sample, the run count restarts. A run of 4 lows, then 1 high, then 4 lows leaves the de-emphasis state off.
- R6: In external mode the de-emphasis state is forced off and pin levels are not sampled. After a return to internal mode, a fresh run of 5 samples is needed before de-emphasis turns on.
- R7: `deemph_o` is high only when the de-emphasis state is on and `single_speed_i` is high. Lowering `single_speed_i` masks the output but keeps the state.
- R8: After reset, `ext_mode_o` and `deemph_o` are both low (internal mode, de-emphasis off).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Shared pin: external bit clock or de-emphasis level (asynchronous) |
| frame_i | input | 1 | Frame (left/right) clock (asynchronous) |
| single_speed_i | input | 1 | High when the sample rate is in the single-speed range |
| ext_mode_o | output | 1 | High in external bit-clock mode |
| deemph_o | output | 1 | De-emphasis enable |

## Verification
The bench places 15 and then 16 edges in one phase to probe the burst threshold. It also splits 20 edges across two phases: a design that counted across frame-clock transitions would wrongly switch to external mode there. It enters external mode during a low phase and checks that the frame holding the burst is not counted as quiet. An early timeout would drop back to internal mode one frame too soon. For the level filter it breaks a run of lows with a single high, which catches a counter that does not restart. It also holds the pin low through several external-mode frames. A filter that keeps sampling in external mode would then turn de-emphasis on as soon as internal mode returns.

// File: rtl/sp_pkg.sv
package sp_pkg;
    typedef enum logic { MODE_INT = 1'b0, MODE_EXT = 1'b1 } mode_e;
    typedef enum logic { DE_OFF = 1'b0, DE_ON = 1'b1 } de_e;
endpackage

// File: rtl/sp_sync_edge.sv
module sp_sync_edge #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] chain [STAGES];
    logic [W-1:0] prev_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= chain[STAGES-1];
    end

    assign level_o = chain[STAGES-1];
    assign rise_o  = chain[STAGES-1] & ~prev_q;
    assign fall_o  = ~chain[STAGES-1] & prev_q;
endmodule

// File: rtl/sp_mode_fsm.sv
module sp_mode_fsm
    import sp_pkg::*;
#(
    parameter int EDGE_THRESH  = 16,
    parameter int QUIET_FRAMES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pin_rise,
    input  logic  frame_rise,
    input  logic  frame_fall,
    output mode_e mode_q
);
    localparam int CW = $clog2(EDGE_THRESH + 1);
    localparam int QW = $clog2(QUIET_FRAMES + 1);

    mode_e         mode_d;
    logic [CW-1:0] edge_cnt;
    logic [QW-1:0] quiet_cnt;
    logic          seen_q;
    logic          seen_now;
    logic          phase_flip;

    assign phase_flip = frame_rise | frame_fall;
    // a rise coinciding with the closing fall belongs to the closing frame
    assign seen_now   = seen_q | pin_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                       edge_cnt <= '0;
        else if (phase_flip)                              edge_cnt <= '0;
        else if (pin_rise && edge_cnt != CW'(EDGE_THRESH)) edge_cnt <= edge_cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          seen_q <= 1'b0;
        else if (frame_fall) seen_q <= 1'b0;
        else if (pin_rise)   seen_q <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   quiet_cnt <= '0;
        else if (mode_q == MODE_INT)  quiet_cnt <= '0;
        else if (frame_fall)          quiet_cnt <= seen_now ? '0 : quiet_cnt + 1'b1;
    end

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_INT: if (pin_rise && !phase_flip && edge_cnt == CW'(EDGE_THRESH - 1))
                          mode_d = MODE_EXT;
            MODE_EXT: if (frame_fall && !seen_now && quiet_cnt == QW'(QUIET_FRAMES - 1))
                          mode_d = MODE_INT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_INT;
        else        mode_q <= mode_d;
    end
endmodule

// File: rtl/sp_deemph_fsm.sv
module sp_deemph_fsm
    import sp_pkg::*;
#(
    parameter int RUN_LEN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_mode,
    input  logic frame_fall,
    input  logic pin_level,
    output de_e  de_q
);
    localparam int RW = $clog2(RUN_LEN + 1);

    de_e           de_d;
    logic [RW-1:0] run_cnt;
    logic          last_lvl;
    logic          same_lvl;
    logic          run_hit;

    assign same_lvl = (pin_level == last_lvl);
    assign run_hit  = frame_fall && !ext_mode &&
                      (same_lvl ? (run_cnt == RW'(RUN_LEN - 1)) : (RUN_LEN == 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt  <= '0;
            last_lvl <= 1'b1;
        end else if (ext_mode) begin
            run_cnt  <= '0;
            last_lvl <= 1'b1;
        end else if (frame_fall) begin
            if (!same_lvl) begin
                run_cnt  <= RW'(1);
                last_lvl <= pin_level;
            end else if (run_cnt != RW'(RUN_LEN)) begin
                run_cnt  <= run_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        de_d = de_q;
        unique case (de_q)
            DE_OFF: if (run_hit && !pin_level) de_d = DE_ON;
            DE_ON:  if (ext_mode)              de_d = DE_OFF;
                    else if (run_hit && pin_level) de_d = DE_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) de_q <= DE_OFF;
        else        de_q <= de_d;
    end
endmodule

// File: rtl/shared_pin_decoder.sv
module shared_pin_decoder
    import sp_pkg::*;
#(
    parameter int EDGE_THRESH  = 16,
    parameter int QUIET_FRAMES = 2,
    parameter int RUN_LEN      = 5,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic frame_i,
    input  logic single_speed_i,
    output logic ext_mode_o,
    output logic deemph_o
);
    logic [1:0] lvl, rise, fall;
    logic       pin_rise, pin_level, frame_rise, frame_fall;
    logic       de_on;
    mode_e      mode_q;
    de_e        de_q;

    sp_sync_edge #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({frame_i, pin_i}),
        .level_o (lvl),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    assign pin_level  = lvl[0];
    assign pin_rise   = rise[0];
    assign frame_rise = rise[1];
    assign frame_fall = fall[1];

    sp_mode_fsm #(.EDGE_THRESH(EDGE_THRESH), .QUIET_FRAMES(QUIET_FRAMES)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_rise   (pin_rise),
        .frame_rise (frame_rise),
        .frame_fall (frame_fall),
        .mode_q     (mode_q)
    );

    sp_deemph_fsm #(.RUN_LEN(RUN_LEN)) u_deemph (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_mode   (mode_q == MODE_EXT),
        .frame_fall (frame_fall),
        .pin_level  (pin_level),
        .de_q       (de_q)
    );

    always_comb begin
        de_on      = (de_q == DE_ON);
        ext_mode_o = (mode_q == MODE_EXT);
        deemph_o   = de_on && (mode_q == MODE_INT) && single_speed_i;
    end
endmodule

// File: rtl/sp_decoder_chk.sv
module sp_decoder_chk (
    input logic clk,
    input logic rst_n,
    input logic pin_rise,
    input logic frame_fall,
    input logic ext_mode,
    input logic de_on
);
    AST_EXT_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_mode) |-> $past(pin_rise)); // R1

    AST_INT_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ext_mode) |-> $past(frame_fall)); // R3

    AST_DE_MOVES_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(de_on) && !$past(ext_mode)) |-> $past(frame_fall)); // R4

    AST_EXT_CLEARS_DE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mode |=> !de_on); // R6
endmodule

bind shared_pin_decoder sp_decoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_rise   (pin_rise),
    .frame_fall (frame_fall),
    .ext_mode   (ext_mode_o),
    .de_on      (de_on)
);

// File: tb/sim_shared_pin_decoder.sv
module sim_shared_pin_decoder;
    localparam int PH = 80;
    localparam int NSTEP = 23;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin = 1'b1;
    logic frame = 1'b0;
    logic ss = 1'b1;
    logic ext_o, de_o;
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    always #2.5 clk = ~clk;

    shared_pin_decoder u0 (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .frame_i(frame),
        .single_speed_i(ss), .ext_mode_o(ext_o), .deemph_o(de_o)
    );

    // {rising edges in high phase [5:0], pin level, expected ext, expected de}
    localparam logic [8:0] STEPS [NSTEP] = '{
        {6'd0,  1'b1, 1'b0, 1'b0},  // R8 idle high
        {6'd0,  1'b0, 1'b0, 1'b0},  // R4 low 1
        {6'd0,  1'b0, 1'b0, 1'b0},  // low 2
        {6'd0,  1'b0, 1'b0, 1'b0},  // low 3
        {6'd0,  1'b0, 1'b0, 1'b0},  // low 4
        {6'd0,  1'b0, 1'b0, 1'b1},  // R4 low 5 -> on
        {6'd0,  1'b1, 1'b0, 1'b1},  // high 1
        {6'd0,  1'b1, 1'b0, 1'b1},
        {6'd0,  1'b1, 1'b0, 1'b1},
        {6'd0,  1'b1, 1'b0, 1'b1},
        {6'd0,  1'b1, 1'b0, 1'b0},  // R4 high 5 -> off
        {6'd15, 1'b1, 1'b0, 1'b0},  // R1 one short
        {6'd16, 1'b1, 1'b1, 1'b0},  // R1 threshold
        {6'd5,  1'b1, 1'b1, 1'b0},  // R3 active frame
        {6'd0,  1'b1, 1'b1, 1'b0},  // quiet 1
        {6'd3,  1'b1, 1'b1, 1'b0},  // R3 restart
        {6'd0,  1'b1, 1'b1, 1'b0},  // quiet 1
        {6'd0,  1'b1, 1'b0, 1'b0},  // R3 quiet 2 -> internal
        {6'd0,  1'b0, 1'b0, 1'b0},
        {6'd0,  1'b0, 1'b0, 1'b0},
        {6'd0,  1'b0, 1'b0, 1'b0},
        {6'd0,  1'b0, 1'b0, 1'b0},
        {6'd0,  1'b0, 1'b0, 1'b1}   // R4 fifth low -> on
    };

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            pin = 1'b0; wait_clk(2);
            pin = 1'b1; wait_clk(2);
        end
    endtask

    task automatic phase(input logic f, input int n, input logic lvl);
        frame = f;
        wait_clk(2);
        pulses(n);
        pin = lvl;
        wait_clk(PH - 2 - 4 * n);
    endtask

    task automatic frame_step(input int hi, input int lo, input logic lvl);
        phase(1'b1, hi, lvl);
        phase(1'b0, lo, lvl);
    endtask

    initial begin
        wait_clk(4);
        check(ext_o, 1'b0, "R8 reset mode");
        check(de_o, 1'b0, "R8 reset deemph");
        rst_n = 1'b1;
        wait_clk(4);

        for (int s = 0; s < NSTEP; s++) begin
            frame_step(int'(STEPS[s][8:3]), 0, STEPS[s][2]);
            check(ext_o, STEPS[s][1], $sformatf("R1/R3 table step %0d", s));
            check(de_o, STEPS[s][0], $sformatf("R4/R6 table step %0d", s));
        end

        // R6: pin low throughout external mode must not count toward a run
        frame_step(16, 0, 1'b0);
        check(ext_o, 1'b1, "R1 enter ext");
        check(de_o, 1'b0, "R6 forced off in ext");
        for (int k = 0; k < 4; k++) frame_step(4, 0, 1'b0);
        check(de_o, 1'b0, "R6 low ignored in ext");
        frame_step(0, 0, 1'b0);
        check(ext_o, 1'b1, "R3 one quiet frame");
        frame_step(0, 0, 1'b0);
        check(ext_o, 1'b0, "R3 two quiet frames");
        check(de_o, 1'b0, "R6 off after return");
        frame_step(0, 0, 1'b0);
        check(de_o, 1'b0, "R6 first sample after return");
        for (int k = 0; k < 4; k++) frame_step(0, 0, 1'b0);
        check(de_o, 1'b1, "R6 fresh run of five");

        // R7: single-speed gate
        ss = 1'b0; wait_clk(2);
        check(de_o, 1'b0, "R7 masked");
        ss = 1'b1; wait_clk(2);
        check(de_o, 1'b1, "R7 state kept");

        // R5: interrupted run
        for (int k = 0; k < 5; k++) frame_step(0, 0, 1'b1);
        check(de_o, 1'b0, "R4 off after highs");
        for (int k = 0; k < 4; k++) frame_step(0, 0, 1'b0);
        frame_step(0, 0, 1'b1);
        for (int k = 0; k < 4; k++) frame_step(0, 0, 1'b0);
        check(de_o, 1'b0, "R5 broken run");
        frame_step(0, 0, 1'b0);
        check(de_o, 1'b1, "R5 run completes");

        // R2: split edges
        for (int k = 0; k < 5; k++) frame_step(0, 0, 1'b1);
        frame_step(10, 10, 1'b1);
        check(ext_o, 1'b0, "R2 split edges");

        // R1 in low phase, R3 burst frame not quiet
        frame_step(0, 16, 1'b1);
        check(ext_o, 1'b1, "R1 low-phase burst");
        frame_step(0, 0, 1'b1);
        check(ext_o, 1'b1, "R3 burst frame not quiet");
        frame_step(0, 0, 1'b1);
        check(ext_o, 1'b1, "R3 first quiet");
        frame_step(0, 0, 1'b1);
        check(ext_o, 1'b0, "R3 second quiet");

        // R8: reset from external mode
        frame_step(16, 0, 1'b1);
        check(ext_o, 1'b1, "R1 re-enter");
        rst_n = 1'b0; wait_clk(2);
        check(ext_o, 1'b0, "R8 reset in ext");
        check(de_o, 1'b0, "R8 reset deemph");
        rst_n = 1'b1; wait_clk(4);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule